// File: doc/BRIEF.md
# Banked Atomic Lock Unit with Sleeping Waiters

This block holds a set of one-bit lock words that a cluster of cores reaches through a memory-mapped window. A read of a lock performs an atomic test-and-set: it returns the value the lock had and leaves the lock busy. A write of zero (the free value) releases the lock, and a write of any other value forces it busy. The locks are interleaved across a configurable number of banks. Each bank serves one access per cycle, so cores that target locks in different banks are served in the same cycle. With a single bank, every access in the cluster is serialized.

Each lock is visible at two address windows. In the plain window a test-and-set that finds the lock busy simply returns busy, and the core polls. In the sleep window such a failed test-and-set also enters the core in the lock's waiter mask. When the lock is later released, every core in that mask receives a one-cycle wake pulse and the mask is cleared. A woken core has no ownership and must retry its test-and-set. Locks can be preset busy at reset, so that consumers block until a producer releases them.

Each core has its own request, grant and response signals. A request that is not granted in its cycle has no effect. A granted access always returns its response one cycle after the grant.

Top module: `tas_lock_unit`

## Requirements
- R1: A granted read (test-and-set) returns the lock's previous value in bit 0 of the core's rdata word, with all other bits zero. After it, the lock is busy (1).
- R2: A granted write with wdata equal to zero releases the lock, setting it to 0. A granted write with any nonzero wdata sets the lock to 1.
- R3: Each granted access raises rvalid for that core exactly one cycle after its gnt. rvalid is never raised without a grant in the previous cycle.
- R4: The lock index is addr[LIDX_W-1:0], and lock i lives in bank i mod NBANKS. With 16 banks, cores addressing locks in different banks are all granted in the same cycle.
- R5: With NBANKS = 1, at most one core is granted per cycle, across all locks.
- R6: Each bank grants at most one requesting core per cycle. Among contending cores of the same class, the bank rotates priority round-robin, starting after the last core it granted, so every steadily requesting core is granted within NCORES cycles. A request without a grant has no effect.
- R7: When a bank has both write and read requests in one cycle, a write wins the arbitration, so a release is applied before a competing test-and-set.
- R8: Address bit LIDX_W set selects the sleep window. There, a test-and-set on a busy lock adds the core to that lock's waiter mask. On a free lock it acquires the lock like a plain test-and-set.
- R9: A release pulses wake, for exactly the cores in the lock's waiter mask, in the cycle of the release's rvalid, and clears the mask. A later release of the same lock wakes nobody.
- R10: A plain-window test-and-set, and a sleep-window test-and-set that acquires the lock, register no waiter.
- R11: Lock i is 1 (busy) after reset when INIT_BUSY[i] is set, and 0 otherwise.
- R12: While rst is high, gnt, rvalid and wake are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NCORES | Per-core access request |
| we | input | NCORES | Per-core write enable (1 = write, 0 = test-and-set read) |
| addr | input | NCORES*(LIDX_W+1) | Per-core address: lock index in the low bits, sleep-window select in the top bit |
| wdata | input | NCORES*DATA_W | Per-core write data; zero releases the lock |
| gnt | output | NCORES | Per-core grant, same cycle as the request |
| rvalid | output | NCORES | Per-core response valid, one cycle after the grant |
| rdata | output | NCORES*DATA_W | Per-core read data: previous lock value in bit 0 |
| wake | output | NCORES | Per-core one-cycle wake pulse on release of a lock the core sleeps on |

## Verification
The bench builds two copies of the unit side by side from the same stimulus: 4 cores, 32 locks, locks 0 and 1 preset busy, one copy with 16 banks and the other with a single bank. The shared stimulus shows that the banked copy grants cross-bank requests together while the single-bank copy serializes them. The small core count makes round-robin rotation and write-first precedence visible within a few cycles. The 32 locks give two locks per bank in the banked copy, so random traffic also hits same-bank contention between distinct locks.

// File: rtl/tas_lock_pkg.sv
package tas_lock_pkg;

    localparam logic LOCK_FREE = 1'b0;
    localparam logic LOCK_BUSY = 1'b1;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_TAS   = 2'd1,
        OP_SLEEP = 2'd2,
        OP_WRITE = 2'd3
    } lock_op_e;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tas_rr_arbiter.sv
module tas_rr_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    localparam int IW = tas_lock_pkg::idx_width(N);

    logic [IW-1:0] last_q;
    logic [IW-1:0] win_idx;
    logic          found;

    always_comb begin
        int k;
        gnt_o   = '0;
        found   = 1'b0;
        win_idx = '0;
        for (int i = 1; i <= N; i++) begin
            k = (int'(last_q) + i) % N;
            if (!found && req_i[k]) begin
                gnt_o[k] = 1'b1;
                win_idx  = IW'(k);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IW'(N - 1);
        end else if (found) begin
            last_q <= win_idx;
        end
    end

endmodule

// File: rtl/tas_port_decode.sv
module tas_port_decode #(
    parameter int LIDX_W = 6,
    parameter int NBANKS = 16,
    parameter int BW     = 4,
    parameter int EW     = 2
) (
    input  logic [LIDX_W:0] addr_i,
    output logic [BW-1:0]   bank_o,
    output logic [EW-1:0]   entry_o,
    output logic            sleep_o
);
    logic [LIDX_W-1:0] idx;

    assign idx     = addr_i[LIDX_W-1:0];
    assign sleep_o = addr_i[LIDX_W];

    generate
        if (NBANKS == 1) begin : g_single
            assign bank_o  = '0;
            assign entry_o = EW'(idx);
        end else begin : g_banked
            assign bank_o  = idx[BW-1:0];
            assign entry_o = EW'(idx >> BW);
        end
    endgenerate

endmodule

// File: rtl/tas_lock_bank.sv
module tas_lock_bank #(
    parameter int                NCORES    = 16,
    parameter int                NLOCKS    = 64,
    parameter int                NBANKS    = 16,
    parameter int                BANK_ID   = 0,
    parameter int                EW        = 2,
    parameter logic [NLOCKS-1:0] INIT_BUSY = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCORES-1:0]    req_i,
    input  logic [NCORES-1:0]    we_i,
    input  logic [NCORES-1:0]    sleep_i,
    input  logic [NCORES-1:0]    free_i,
    input  logic [NCORES*EW-1:0] entry_i,
    output logic [NCORES-1:0]    gnt_o,
    output logic [NCORES-1:0]    rsp_o,
    output logic                 old_o,
    output logic [NCORES-1:0]    wake_o
);
    import tas_lock_pkg::*;

    localparam int ENTRIES = NLOCKS / NBANKS;
    localparam int CW      = idx_width(NCORES);

    logic                lock_q    [ENTRIES];
    logic [NCORES-1:0]   waiters_q [ENTRIES];
    logic [NCORES-1:0]   cand;
    logic [CW-1:0]       sel;
    logic [EW-1:0]       sel_entry;
    lock_op_e            sel_op;
    logic                sel_free;

    // Releases and forced-busy writes outrank test-and-set reads.
    always_comb begin
        if (|(req_i & we_i)) cand = req_i & we_i;
        else                 cand = req_i;
    end

    tas_rr_arbiter #(.N(NCORES)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req_i (cand),
        .gnt_o (gnt_o)
    );

    always_comb begin
        sel = '0;
        for (int c = 0; c < NCORES; c++) begin
            if (gnt_o[c]) sel = CW'(c);
        end
        sel_entry = entry_i[sel*EW +: EW];
        sel_free  = free_i[sel];
        if (!(|gnt_o))        sel_op = OP_IDLE;
        else if (we_i[sel])   sel_op = OP_WRITE;
        else if (sleep_i[sel]) sel_op = OP_SLEEP;
        else                  sel_op = OP_TAS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) begin
                lock_q[e]    <= INIT_BUSY[e*NBANKS + BANK_ID];
                waiters_q[e] <= '0;
            end
            rsp_o  <= '0;
            old_o  <= 1'b0;
            wake_o <= '0;
        end else begin
            rsp_o  <= gnt_o;
            wake_o <= '0;
            if (sel_op != OP_IDLE) old_o <= lock_q[sel_entry];
            case (sel_op)
                OP_WRITE: begin
                    if (sel_free) begin
                        lock_q[sel_entry]    <= LOCK_FREE;
                        wake_o               <= waiters_q[sel_entry];
                        waiters_q[sel_entry] <= '0;
                    end else begin
                        lock_q[sel_entry] <= LOCK_BUSY;
                    end
                end
                OP_SLEEP: begin
                    lock_q[sel_entry] <= LOCK_BUSY;
                    if (lock_q[sel_entry] == LOCK_BUSY)
                        waiters_q[sel_entry][sel] <= 1'b1;
                end
                OP_TAS: begin
                    lock_q[sel_entry] <= LOCK_BUSY;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tas_lock_unit.sv
module tas_lock_unit #(
    parameter int                NCORES    = 16,
    parameter int                NLOCKS    = 64,
    parameter int                NBANKS    = 16,
    parameter int                DATA_W    = 32,
    parameter logic [NLOCKS-1:0] INIT_BUSY = '0,
    localparam int               LIDX_W    = $clog2(NLOCKS),
    localparam int               AW        = LIDX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCORES-1:0]        req,
    input  logic [NCORES-1:0]        we,
    input  logic [NCORES*AW-1:0]     addr,
    input  logic [NCORES*DATA_W-1:0] wdata,
    output logic [NCORES-1:0]        gnt,
    output logic [NCORES-1:0]        rvalid,
    output logic [NCORES*DATA_W-1:0] rdata,
    output logic [NCORES-1:0]        wake
);
    import tas_lock_pkg::*;

    localparam int ENTRIES = NLOCKS / NBANKS;
    localparam int BW      = idx_width(NBANKS);
    localparam int EW      = idx_width(ENTRIES);

    generate
        if (!is_pow2(NBANKS) || !is_pow2(NLOCKS) || NLOCKS < NBANKS) begin : g_bad_cfg
            $error("tas_lock_unit: NBANKS and NLOCKS must be powers of two with NLOCKS >= NBANKS");
        end
    endgenerate

    logic [BW-1:0]        bank_of [NCORES];
    logic [NCORES*EW-1:0] entry_flat;
    logic [NCORES-1:0]    sleep_vec;
    logic [NCORES-1:0]    free_vec;

    logic [NCORES-1:0]    bank_req  [NBANKS];
    logic [NCORES-1:0]    bank_gnt  [NBANKS];
    logic [NCORES-1:0]    bank_rsp  [NBANKS];
    logic [NCORES-1:0]    bank_wake [NBANKS];
    logic                 bank_old  [NBANKS];

    generate
        for (genvar c = 0; c < NCORES; c++) begin : g_port
            tas_port_decode #(
                .LIDX_W (LIDX_W),
                .NBANKS (NBANKS),
                .BW     (BW),
                .EW     (EW)
            ) u_dec (
                .addr_i  (addr[c*AW +: AW]),
                .bank_o  (bank_of[c]),
                .entry_o (entry_flat[c*EW +: EW]),
                .sleep_o (sleep_vec[c])
            );
            assign free_vec[c] = (wdata[c*DATA_W +: DATA_W] == '0);
        end

        for (genvar b = 0; b < NBANKS; b++) begin : g_bank
            always_comb begin
                for (int c = 0; c < NCORES; c++)
                    bank_req[b][c] = req[c] && !rst && (bank_of[c] == BW'(b));
            end

            tas_lock_bank #(
                .NCORES    (NCORES),
                .NLOCKS    (NLOCKS),
                .NBANKS    (NBANKS),
                .BANK_ID   (b),
                .EW        (EW),
                .INIT_BUSY (INIT_BUSY)
            ) u_bank (
                .clk     (clk),
                .rst     (rst),
                .req_i   (bank_req[b]),
                .we_i    (we),
                .sleep_i (sleep_vec),
                .free_i  (free_vec),
                .entry_i (entry_flat),
                .gnt_o   (bank_gnt[b]),
                .rsp_o   (bank_rsp[b]),
                .old_o   (bank_old[b]),
                .wake_o  (bank_wake[b])
            );
        end
    endgenerate

    always_comb begin
        gnt    = '0;
        rvalid = '0;
        wake   = '0;
        rdata  = '0;
        for (int b = 0; b < NBANKS; b++) begin
            for (int c = 0; c < NCORES; c++) begin
                gnt[c]           |= bank_gnt[b][c];
                rvalid[c]        |= bank_rsp[b][c];
                wake[c]          |= bank_wake[b][c];
                rdata[c*DATA_W]  |= bank_rsp[b][c] & bank_old[b];
            end
        end
    end

endmodule

// File: rtl/tas_lock_unit_chk.sv
module tas_lock_unit_chk #(
    parameter int NCORES = 16,
    parameter int NLOCKS = 64,
    parameter int NBANKS = 16,
    parameter int LIDX_W = $clog2(NLOCKS),
    parameter int AW     = LIDX_W + 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NCORES-1:0]    req,
    input logic [NCORES-1:0]    we,
    input logic [NCORES*AW-1:0] addr,
    input logic [NCORES-1:0]    gnt,
    input logic [NCORES-1:0]    rvalid,
    input logic [NCORES-1:0]    wake
);
    logic [NCORES-1:0] inb [NBANKS];

    always_comb begin
        for (int b = 0; b < NBANKS; b++)
            for (int c = 0; c < NCORES; c++)
                inb[b][c] = ((int'(addr[c*AW +: LIDX_W]) % NBANKS) == b);
    end

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (gnt == '0 || rst) && rvalid == '0 && wake == '0);

    // R6
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    // R3
    rsp_follows_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid == $past(gnt));

    // R5
    single_port_chk: assert property (@(posedge clk) disable iff (rst)
        (NBANKS != 1) || $onehot0(gnt));

    // R9
    wake_with_release_chk: assert property (@(posedge clk) disable iff (rst)
        (|wake) |-> $past(|(gnt & we)));

    generate
        for (genvar b = 0; b < NBANKS; b++) begin : g_bank_chk
            // R6
            bank_one_grant_chk: assert property (@(posedge clk) disable iff (rst)
                $countones(gnt & inb[b]) <= 1);
            // R7
            release_first_chk: assert property (@(posedge clk) disable iff (rst)
                (|(req & we & inb[b])) |-> !(|(gnt & ~we & inb[b])));
        end
    endgenerate

endmodule

bind tas_lock_unit tas_lock_unit_chk #(
    .NCORES (NCORES),
    .NLOCKS (NLOCKS),
    .NBANKS (NBANKS)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .we     (we),
    .addr   (addr),
    .gnt    (gnt),
    .rvalid (rvalid),
    .wake   (wake)
);

// File: tb/tas_lock_unit_bench.sv
`timescale 1ns/1ps
module tas_lock_unit_bench;

    localparam int NC  = 4;
    localparam int NL  = 32;
    localparam int DW  = 32;
    localparam int LW  = 5;
    localparam int AW  = LW + 1;
    localparam logic [NL-1:0] INIT = 32'h0000_0003;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NC-1:0]    req = '0;
    logic [NC-1:0]    we  = '0;
    logic [NC*AW-1:0] addr = '0;
    logic [NC*DW-1:0] wdata = '0;

    logic [NC-1:0]    gnt_o  [2];
    logic [NC-1:0]    rv_o   [2];
    logic [NC*DW-1:0] rd_o   [2];
    logic [NC-1:0]    wk_o   [2];

    tas_lock_unit #(.NCORES(NC), .NLOCKS(NL), .NBANKS(16), .DATA_W(DW), .INIT_BUSY(INIT)) u_tas_lock_unit (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .gnt(gnt_o[0]), .rvalid(rv_o[0]), .rdata(rd_o[0]), .wake(wk_o[0]));

    tas_lock_unit #(.NCORES(NC), .NLOCKS(NL), .NBANKS(1), .DATA_W(DW), .INIT_BUSY(INIT)) u_tas_lock_unit_b1 (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .gnt(gnt_o[1]), .rvalid(rv_o[1]), .rdata(rd_o[1]), .wake(wk_o[1]));

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit        lockm [2][NL];
    bit [NC-1:0] waitm [2][NL];
    int        lastg [2][16];
    bit [NC-1:0] exp_rv [2];
    bit [NC-1:0] exp_rd [2];
    bit [NC-1:0] exp_wk [2];

    function automatic int lk_of(int c);
        return int'(addr[c*AW +: LW]);
    endfunction

    task automatic model_reset(int k);
        for (int i = 0; i < NL; i++) begin lockm[k][i] = INIT[i]; waitm[k][i] = '0; end
        for (int b = 0; b < 16; b++) lastg[k][b] = NC - 1;
        exp_rv[k] = '0; exp_rd[k] = '0; exp_wk[k] = '0;
    endtask

    task automatic model_step(int k);
        int nb;
        bit [NC-1:0] eg;
        bit [NC-1:0] nrv, nrd, nwk;
        nb = (k == 0) ? 16 : 1;
        eg = '0;
        for (int b = 0; b < nb; b++) begin
            bit [NC-1:0] cand;
            bit anyw;
            cand = '0; anyw = 0;
            for (int c = 0; c < NC; c++)
                if (req[c] && (lk_of(c) % nb) == b) begin
                    cand[c] = 1;
                    if (we[c]) anyw = 1;
                end
            if (anyw) cand = cand & we;
            for (int i = 1; i <= NC; i++) begin
                int c;
                c = (lastg[k][b] + i) % NC;
                if (cand[c]) begin eg[c] = 1; lastg[k][b] = c; break; end
            end
        end
        chk(k == 0 ? "R4 gnt banked" : "R5 gnt single", 32'(gnt_o[k]), 32'(eg));
        chk("R3 rvalid", 32'(rv_o[k]), 32'(exp_rv[k]));
        chk("R9 wake", 32'(wk_o[k]), 32'(exp_wk[k]));
        for (int c = 0; c < NC; c++)
            chk("R1 rdata", rd_o[k][c*DW +: DW], {31'b0, exp_rd[k][c] & exp_rv[k][c]});
        nrv = '0; nrd = '0; nwk = '0;
        for (int c = 0; c < NC; c++) if (eg[c]) begin
            int i;
            i = lk_of(c);
            nrv[c] = 1;
            nrd[c] = lockm[k][i];
            if (we[c]) begin
                if (wdata[c*DW +: DW] == 0) begin
                    lockm[k][i] = 0; nwk |= waitm[k][i]; waitm[k][i] = '0;
                end else lockm[k][i] = 1;
            end else begin
                if (addr[c*AW + LW] && lockm[k][i]) waitm[k][i][c] = 1;
                lockm[k][i] = 1;
            end
        end
        exp_rv[k] = nrv; exp_rd[k] = nrd; exp_wk[k] = nwk;
    endtask

    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                chk("R12 gnt in reset", 32'(gnt_o[k]), 0);
                model_reset(k);
            end else model_step(k);
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic clr();
        req = '0; we = '0; addr = '0; wdata = '0;
    endtask

    task automatic setc(int c, bit w, bit sl, int lk, logic [31:0] wd);
        req[c] = 1; we[c] = w;
        addr[c*AW +: AW] = {sl, LW'(lk)};
        wdata[c*DW +: DW] = wd;
    endtask

    task automatic cyc1();
        @(posedge clk); #1;
    endtask

    // one single-core access: checks grant, then response word
    task automatic single(string tag, int c, bit w, bit sl, int lk, logic [31:0] wd, bit exp_old);
        cyc1(); clr(); setc(c, w, sl, lk, wd);
        @(negedge clk);
        for (int k = 0; k < 2; k++) chk({tag, " gnt"}, 32'(gnt_o[k]), 32'(1 << c));
        cyc1(); clr();
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk({tag, " rvalid"}, 32'(rv_o[k]), 32'(1 << c));
            chk({tag, " rdata"}, rd_o[k][c*DW +: DW], {31'b0, exp_old});
        end
    endtask

    task automatic release_wake(string tag, int c, int lk, bit [NC-1:0] exp_w);
        cyc1(); clr(); setc(c, 1, 0, lk, 0);
        @(negedge clk);
        for (int k = 0; k < 2; k++) chk({tag, " no early wake"}, 32'(wk_o[k]), 0);
        cyc1(); clr();
        @(negedge clk);
        for (int k = 0; k < 2; k++) chk(tag, 32'(wk_o[k]), 32'(exp_w));
    endtask

    initial begin
        bit [NC-1:0] seen [2];
        clr();
        // R12: request during reset is ignored
        repeat (2) cyc1();
        setc(0, 0, 0, 5, 0);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk("R12 gnt in reset", 32'(gnt_o[k]), 0);
            chk("R12 rvalid in reset", 32'(rv_o[k]), 0);
        end
        cyc1(); clr(); rst = 0;

        single("R11 preset busy", 0, 0, 0, 0, 0, 1'b1);
        single("R1 first tas", 0, 0, 0, 5, 0, 1'b0);
        single("R1 second tas", 0, 0, 0, 5, 0, 1'b1);
        single("R2 release", 0, 1, 0, 5, 0, 1'b1);
        single("R2 after release", 0, 0, 0, 5, 0, 1'b0);
        single("R2 force busy", 0, 1, 0, 6, 32'h7, 1'b0);
        single("R2 after force", 0, 0, 0, 6, 0, 1'b1);

        // R8: sleeping test-and-sets on busy lock 0
        single("R8 sleep c1", 1, 0, 1, 0, 0, 1'b1);
        single("R8 sleep c2", 2, 0, 1, 0, 0, 1'b1);
        release_wake("R9 wake waiters", 0, 0, 4'b0110);
        release_wake("R9 mask cleared", 0, 0, 4'b0000);

        // R10: acquiring sleep TAS and plain TAS register nobody
        single("R8 sleep acquires", 3, 0, 1, 0, 0, 1'b0);
        single("R10 plain busy", 1, 0, 0, 0, 0, 1'b1);
        release_wake("R10 no waiter", 3, 0, 4'b0000);

        // R7: release and test-and-set to the same lock in one cycle
        single("R7 make busy", 0, 1, 0, 2, 32'h1, 1'b0);
        cyc1(); clr(); setc(0, 0, 0, 2, 0); setc(1, 1, 0, 2, 0);
        @(negedge clk);
        for (int k = 0; k < 2; k++) chk("R7 write wins", 32'(gnt_o[k]), 32'b0010);
        cyc1(); clr();
        single("R7 release applied", 0, 0, 0, 2, 0, 1'b0);

        // R4 / R5: four locks in four different banks
        cyc1(); clr();
        for (int c = 0; c < NC; c++) setc(c, 0, 0, 8 + c, 0);
        @(negedge clk);
        chk("R4 parallel banks", 32'(gnt_o[0]), 32'hf);
        chk("R5 single port", 32'($countones(gnt_o[1])), 1);
        cyc1(); clr();

        // R6: four cores on one lock, rotation covers all within NC cycles
        seen[0] = '0; seen[1] = '0;
        cyc1(); clr();
        for (int c = 0; c < NC; c++) setc(c, 0, 0, 12, 0);
        for (int n = 0; n < NC; n++) begin
            @(negedge clk);
            for (int k = 0; k < 2; k++) begin
                chk("R6 one per bank", 32'($countones(gnt_o[k])), 1);
                seen[k] |= gnt_o[k];
            end
            cyc1();
        end
        clr();
        for (int k = 0; k < 2; k++) chk("R6 round robin coverage", 32'(seen[k]), 32'hf);

        // random traffic, compared every cycle by the model
        for (int n = 0; n < 3000; n++) begin
            cyc1(); clr();
            for (int c = 0; c < NC; c++) begin
                if ($urandom_range(0, 1) == 1) begin
                    int lk;
                    lk = $urandom_range(0, 7) + ($urandom_range(0, 1) == 1 ? 16 : 0);
                    setc(c, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, lk,
                         ($urandom_range(0, 1) == 1) ? 32'h0 : $urandom);
                end
            end
        end
        cyc1(); clr();
        repeat (3) cyc1();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule